// File: doc/BRIEF.md
# Page Memory Clearing Engine

This block overwrites a page memory with the space character, 0x20. The memory has two areas: a basic page area and an extension packet area. A clear can come from the acquisition hardware, when a page header arrives that must wipe the old page. It can also come from software, which asks for the whole memory to be blanked. The block owns the memory write port. While a clear runs, its writes win over the acquisition path's writes.

A hardware clear blanks the display rows and the two extension rows that a new page reuses. Each clear walks one row at a time, one column per clock. A hardware clear of the default geometry takes 1000 cycles, so it completes inside the TV line that carried its header.

A software request is held pending and starts only on a line start. If a hardware clear claims the same line, the software clear waits. If a hardware clear interrupts a running software clear, the software clear restarts on a later line. After reset the engine blanks the whole memory at once, with the software busy flag raised. In the mode for independent data services, headers never start a clear. When a software clear completes in that mode, the block sends a reset pulse to the capture logic's packet counter.

Top module: `pgclr_engine`

## Requirements
- R1: A header strobe (`hdr_valid`=1) with `hdr_first`=1 or `hdr_erase`=1 and `ids_mode`=0 starts a hardware clear. Its first write appears in the cycle after the strobe cycle, and one location is written in every following cycle until the clear ends.
- R2: A hardware clear writes 0x20 to every column (0..39) of basic rows 1..23 and of extension row 1 (`mem_area`=1 is the extension area, 0 the basic area). It leaves every other location untouched apart from the row of R3.
- R3: A hardware clear also clears the packet-24 row, using the `p24_in_basic` value sampled with the strobe. When that value is 1 the row is basic row 24; when it is 0 the row is extension row 0.
- R4: A hardware clear makes exactly 1000 writes. `clr_done` is high for one cycle, in the cycle right after the last write.
- R5: A `sw_clear` strobe raises `sw_clear_busy` from the next cycle and makes no write by itself. The full clear starts in the cycle after the next `line_start`. It writes 0x20 to basic rows 0..24 and extension rows 0..3, 1160 writes in total.
- R6: A hardware clear has priority over a software clear. If both fall in the same cycle, the software clear waits for a later `line_start`. A software clear interrupted by a hardware clear gives no `clr_done`, stays pending, and later reruns from the beginning.
- R7: `sw_clear_busy` falls in the same cycle as the `clr_done` of a completed full clear, and at no other time.
- R8: `sw_clear_busy` is 1 and `mem_we` is 0 during reset. After reset the full clear of R5 starts without waiting for `line_start`.
- R9: While `ids_mode`=1, header strobes start no clear and cause no write.
- R10: A full clear that completes with `ids_mode`=1 raises `ids_cnt_rst` for exactly the cycle in which `clr_done` is high. When `ids_mode`=0, `ids_cnt_rst` stays 0.
- R11: When no clear is running, acquisition writes pass to the memory port unchanged. While a clear runs, acquisition writes are dropped.
- R12: `clr_done` gives one single-cycle pulse per completed clear and none for an interrupted clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of each TV line |
| hdr_valid | input | 1 | Page header acquired strobe |
| hdr_first | input | 1 | Header is the first one since a new page request |
| hdr_erase | input | 1 | Erase control bit of the header |
| p24_in_basic | input | 1 | 1: packet-24 row is basic row 24; 0: extension row 0 |
| sw_clear | input | 1 | Software request for a full clear (strobe) |
| ids_mode | input | 1 | Independent data service mode |
| acq_we | input | 1 | Acquisition write enable |
| acq_area | input | 1 | Acquisition area select (1 = extension) |
| acq_row | input | 5 | Acquisition row |
| acq_col | input | 6 | Acquisition column |
| acq_data | input | 8 | Acquisition write data |
| mem_we | output | 1 | Memory write enable |
| mem_area | output | 1 | Memory area select (1 = extension) |
| mem_row | output | 5 | Memory row |
| mem_col | output | 6 | Memory column |
| mem_wdata | output | 8 | Memory write data |
| sw_clear_busy | output | 1 | Software clear pending or in progress |
| clr_done | output | 1 | One-cycle pulse when a clear completes |
| ids_cnt_rst | output | 1 | Packet counter reset for the capture logic |

## Verification
The assertions assume that a line is longer than a full clear, so no `line_start` arrives while a software clear is still running. They also assume that `ids_mode` and `p24_in_basic` hold steady around a header strobe. The bench leaves 1200 or more cycles between line starts and never changes the mode bits while a clear runs. It sweeps all sixteen combinations of first, erase, position and mode over a memory prefilled with a marker. It also steps through the orderings of software requests, headers and line starts that R5 to R8 describe.

// File: rtl/pgclr_pkg.sv
package pgclr_pkg;

    localparam logic [7:0] SPACE_CODE = 8'h20;
    localparam logic       AREA_BASIC = 1'b0;
    localparam logic       AREA_EXT   = 1'b1;

    typedef enum logic {
        JOB_HW   = 1'b0,
        JOB_FULL = 1'b1
    } job_e;

endpackage

// File: rtl/pgclr_request.sv
module pgclr_request
    import pgclr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_start_i,
    input  logic hdr_valid_i,
    input  logic hdr_first_i,
    input  logic hdr_erase_i,
    input  logic sw_req_i,
    input  logic ids_i,
    input  logic active_i,
    input  logic fin_full_i,
    output logic start_o,
    output job_e job_o,
    output logic busy_o
);

    typedef struct packed {
        logic busy;
        logic boot;
    } req_t;

    req_t q, d;
    logic hw_req;
    logic sw_go;

    always_comb begin
        hw_req  = hdr_valid_i && (hdr_first_i || hdr_erase_i) && !ids_i;
        sw_go   = !hw_req && q.busy && !active_i && (line_start_i || q.boot);
        start_o = hw_req || sw_go;
        job_o   = hw_req ? JOB_HW : JOB_FULL;

        d = q;
        if (sw_go) begin
            d.boot = 1'b0;
        end
        if (sw_req_i) begin
            d.busy = 1'b1;
        end else if (fin_full_i && !start_o) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy <= 1'b1;
            q.boot <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;

    AST_IDS_NO_HW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ids_i && start_o) |-> (job_o == JOB_FULL)); // R9

    AST_SW_WAITS_FOR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && job_o == JOB_FULL && !q.boot) |-> line_start_i); // R5

endmodule

// File: rtl/pgclr_sweep.sv
module pgclr_sweep
    import pgclr_pkg::*;
#(
    parameter int COLS      = 40,
    parameter int BASE_ROWS = 25,
    parameter int EXT_ROWS  = 4,
    parameter int ROW_W     = $clog2(BASE_ROWS),
    parameter int COL_W     = $clog2(COLS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  job_e             job_i,
    input  logic             pos_i,
    output logic             valid_o,
    output logic             area_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             fin_o,
    output logic             fin_full_o,
    output logic             done_o,
    output logic             done_full_o
);

    localparam int STEP_W = $clog2(BASE_ROWS + EXT_ROWS);
    localparam logic [STEP_W-1:0] HW_P24    = STEP_W'(BASE_ROWS - 2);
    localparam logic [STEP_W-1:0] HW_LAST   = STEP_W'(BASE_ROWS - 1);
    localparam logic [STEP_W-1:0] FULL_EXT0 = STEP_W'(BASE_ROWS);
    localparam logic [STEP_W-1:0] FULL_LAST = STEP_W'(BASE_ROWS + EXT_ROWS - 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0]  P24_ROW   = ROW_W'(BASE_ROWS - 1);

    typedef struct packed {
        logic              active;
        job_e              job;
        logic              pos;
        logic [STEP_W-1:0] step;
        logic [COL_W-1:0]  col;
        logic              done;
        logic              done_full;
    } sweep_t;

    sweep_t q, d;
    logic   last_col;
    logic   last_step;

    always_comb begin
        last_col   = (q.col == COL_LAST);
        last_step  = (q.job == JOB_HW) ? (q.step == HW_LAST) : (q.step == FULL_LAST);
        fin_o      = q.active && last_col && last_step;
        fin_full_o = fin_o && (q.job == JOB_FULL);

        d           = q;
        d.done      = 1'b0;
        d.done_full = 1'b0;
        if (start_i) begin
            d.active = 1'b1;
            d.job    = job_i;
            d.pos    = pos_i;
            d.step   = '0;
            d.col    = '0;
        end else if (q.active) begin
            if (last_col) begin
                d.col = '0;
                if (last_step) begin
                    d.active    = 1'b0;
                    d.done      = 1'b1;
                    d.done_full = (q.job == JOB_FULL);
                end else begin
                    d.step = q.step + 1'b1;
                end
            end else begin
                d.col = q.col + 1'b1;
            end
        end
    end

    always_comb begin
        area_o = AREA_BASIC;
        row_o  = '0;
        if (q.job == JOB_HW) begin
            if (q.step < HW_P24) begin
                row_o = ROW_W'(q.step) + ROW_W'(1);
            end else if (q.step == HW_P24) begin
                if (q.pos) begin
                    row_o = P24_ROW;
                end else begin
                    area_o = AREA_EXT;
                end
            end else begin
                area_o = AREA_EXT;
                row_o  = ROW_W'(1);
            end
        end else begin
            if (q.step < FULL_EXT0) begin
                row_o = ROW_W'(q.step);
            end else begin
                area_o = AREA_EXT;
                row_o  = ROW_W'(q.step - FULL_EXT0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_o     = q.active;
    assign col_o       = q.col;
    assign done_o      = q.done;
    assign done_full_o = q.done_full;

    AST_ROW_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((area_o == AREA_EXT) ? (int'(row_o) < EXT_ROWS)
                                          : (int'(row_o) < BASE_ROWS))); // R2

    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(col_o) < COLS)); // R2

    AST_HW_SKIPS_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && q.job == JOB_HW && area_o == AREA_BASIC) |-> (row_o != '0)); // R2

endmodule

// File: rtl/pgclr_engine.sv
module pgclr_engine
    import pgclr_pkg::*;
#(
    parameter  int COLS      = 40,
    parameter  int BASE_ROWS = 25,
    parameter  int EXT_ROWS  = 4,
    localparam int ROW_W     = $clog2(BASE_ROWS),
    localparam int COL_W     = $clog2(COLS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             hdr_valid,
    input  logic             hdr_first,
    input  logic             hdr_erase,
    input  logic             p24_in_basic,
    input  logic             sw_clear,
    input  logic             ids_mode,
    input  logic             acq_we,
    input  logic             acq_area,
    input  logic [ROW_W-1:0] acq_row,
    input  logic [COL_W-1:0] acq_col,
    input  logic [7:0]       acq_data,
    output logic             mem_we,
    output logic             mem_area,
    output logic [ROW_W-1:0] mem_row,
    output logic [COL_W-1:0] mem_col,
    output logic [7:0]       mem_wdata,
    output logic             sw_clear_busy,
    output logic             clr_done,
    output logic             ids_cnt_rst
);

    typedef struct packed {
        logic cnt_rst;
    } top_t;

    top_t             q, d;
    logic             start;
    job_e             job;
    logic             sweep_valid;
    logic             sweep_area;
    logic [ROW_W-1:0] sweep_row;
    logic [COL_W-1:0] sweep_col;
    logic             sweep_fin;
    logic             sweep_fin_full;
    logic             sweep_done;
    logic             sweep_done_full;

    pgclr_request u_request (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start),
        .hdr_valid_i  (hdr_valid),
        .hdr_first_i  (hdr_first),
        .hdr_erase_i  (hdr_erase),
        .sw_req_i     (sw_clear),
        .ids_i        (ids_mode),
        .active_i     (sweep_valid),
        .fin_full_i   (sweep_fin_full),
        .start_o      (start),
        .job_o        (job),
        .busy_o       (sw_clear_busy)
    );

    pgclr_sweep #(
        .COLS      (COLS),
        .BASE_ROWS (BASE_ROWS),
        .EXT_ROWS  (EXT_ROWS),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .job_i       (job),
        .pos_i       (p24_in_basic),
        .valid_o     (sweep_valid),
        .area_o      (sweep_area),
        .row_o       (sweep_row),
        .col_o       (sweep_col),
        .fin_o       (sweep_fin),
        .fin_full_o  (sweep_fin_full),
        .done_o      (sweep_done),
        .done_full_o (sweep_done_full)
    );

    always_comb begin
        d         = q;
        d.cnt_rst = sweep_fin_full && !start && ids_mode;

        if (sweep_valid) begin
            mem_we    = 1'b1;
            mem_area  = sweep_area;
            mem_row   = sweep_row;
            mem_col   = sweep_col;
            mem_wdata = SPACE_CODE;
        end else begin
            mem_we    = acq_we;
            mem_area  = acq_area;
            mem_row   = acq_row;
            mem_col   = acq_col;
            mem_wdata = acq_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign clr_done    = sweep_done;
    assign ids_cnt_rst = q.cnt_rst;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |=> !clr_done); // R12

    AST_BUSY_FALL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_clear_busy) |-> (clr_done && sweep_done_full)); // R7

    AST_CNT_RST_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ids_cnt_rst |-> (clr_done && sweep_done_full)); // R10

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_done |-> $past(mem_we)); // R4

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !$past(start)) |-> !sweep_valid); // R12

endmodule

// File: tb/test_pgclr_engine.sv
`timescale 1ns/1ps
module test_pgclr_engine;

    localparam int COLS  = 40;
    localparam int BROWS = 25;
    localparam int EROWS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0, hdr_valid = 1'b0, hdr_first = 1'b0, hdr_erase = 1'b0;
    logic       p24_in_basic = 1'b0, sw_clear = 1'b0, ids_mode = 1'b0;
    logic       acq_we = 1'b0, acq_area = 1'b0;
    logic [4:0] acq_row = '0;
    logic [5:0] acq_col = '0;
    logic [7:0] acq_data = '0;
    logic       mem_we, mem_area;
    logic [4:0] mem_row;
    logic [5:0] mem_col;
    logic [7:0] mem_wdata;
    logic       sw_clear_busy, clr_done, ids_cnt_rst;

    always #2 clk = ~clk;

    pgclr_engine i_pgclr_engine (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .hdr_valid(hdr_valid),
        .hdr_first(hdr_first), .hdr_erase(hdr_erase), .p24_in_basic(p24_in_basic),
        .sw_clear(sw_clear), .ids_mode(ids_mode), .acq_we(acq_we), .acq_area(acq_area),
        .acq_row(acq_row), .acq_col(acq_col), .acq_data(acq_data), .mem_we(mem_we),
        .mem_area(mem_area), .mem_row(mem_row), .mem_col(mem_col), .mem_wdata(mem_wdata),
        .sw_clear_busy(sw_clear_busy), .clr_done(clr_done), .ids_cnt_rst(ids_cnt_rst)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [2][BROWS][COLS];
    int ncyc = 0, wr_cnt = 0, first_we = -1, last_we = -1;
    int done_cnt = 0, done_at = -1, rst_cnt = 0, rst_at = -1, fall_at = -1;
    logic prev_busy = 1'b1;

    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (rst_n) begin
            if (mem_we) begin
                shadow[mem_area][mem_row][mem_col] = mem_wdata;
                wr_cnt = wr_cnt + 1;
                if (first_we < 0) first_we = ncyc;
                last_we = ncyc;
            end
            if (clr_done) begin done_cnt = done_cnt + 1; done_at = ncyc; end
            if (ids_cnt_rst) begin rst_cnt = rst_cnt + 1; rst_at = ncyc; end
            if (prev_busy && !sw_clear_busy) fall_at = ncyc;
            prev_busy = sw_clear_busy;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic clr_stats();
        wr_cnt = 0; first_we = -1; last_we = -1; done_cnt = 0; done_at = -1;
        rst_cnt = 0; rst_at = -1; fall_at = -1;
    endtask

    task automatic fill(input logic [7:0] v);
        for (int a = 0; a < 2; a++)
            for (int r = 0; r < (a == 0 ? BROWS : EROWS); r++)
                for (int c = 0; c < COLS; c++) begin
                    acq_we = 1'b1; acq_area = a[0]; acq_row = r[4:0];
                    acq_col = c[5:0]; acq_data = v;
                    tick();
                end
        acq_we = 1'b0;
        tick();
    endtask

    task automatic pulse_hdr(input logic f, input logic e, input logic p, input logic ls);
        hdr_valid = 1'b1; hdr_first = f; hdr_erase = e; p24_in_basic = p; line_start = ls;
        tick();
        hdr_valid = 1'b0; hdr_first = 1'b0; hdr_erase = 1'b0; line_start = 1'b0;
    endtask

    task automatic pulse_line();
        line_start = 1'b1; tick(); line_start = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_clear = 1'b1; tick(); sw_clear = 1'b0;
    endtask

    // mode 0: none cleared, 1: hardware rows, 2: everything
    task automatic verify_mem(input int mode, input logic pos, input logic [7:0] bg,
                              input string req);
        int bad = 0, ba = 0, exp_v = 0;
        for (int a = 0; a < 2; a++)
            for (int r = 0; r < (a == 0 ? BROWS : EROWS); r++) begin
                bit clr;
                if (mode == 2) clr = 1'b1;
                else if (mode == 1)
                    clr = (a == 0) ? ((r >= 1 && r <= 23) || (r == 24 && pos))
                                   : (r == 1 || (r == 0 && !pos));
                else clr = 1'b0;
                for (int c = 0; c < COLS; c++)
                    if (shadow[a][r][c] != (clr ? 8'h20 : bg)) begin
                        if (bad == 0) begin ba = shadow[a][r][c]; exp_v = clr ? 32 : int'(bg); end
                        bad++;
                    end
            end
        check(bad == 0, req, ba, exp_v);
    endtask

    initial begin
        int mark;
        for (int a = 0; a < 2; a++)
            for (int r = 0; r < BROWS; r++)
                for (int c = 0; c < COLS; c++) shadow[a][r][c] = 8'h55;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check(sw_clear_busy == 1'b1, "R8 busy in reset", sw_clear_busy, 1);
        check(mem_we == 1'b0, "R8 no write in reset", mem_we, 0);
        rst_n = 1'b1;
        clr_stats();
        mark = ncyc;
        repeat (1250) tick();
        check(first_we == mark + 2, "R8 boot clear start", first_we, mark + 2);
        check(wr_cnt == 1160, "R8 boot write count", wr_cnt, 1160);
        check(fall_at == done_at && done_cnt == 1, "R7 busy fall at boot done", fall_at, done_at);
        check(rst_cnt == 0, "R10 no counter reset outside ids", rst_cnt, 0);
        verify_mem(2, 1'b0, 8'h55, "R8 boot memory");

        // R1 R2 R3 R4 R9 R12: sweep of header controls
        for (int k = 0; k < 16; k++) begin
            logic f, e, p, im;
            bit trig;
            f = k[0]; e = k[1]; p = k[2]; im = k[3];
            ids_mode = im;
            fill(8'hAA);
            clr_stats();
            pulse_hdr(f, e, p, 1'b0);
            mark = ncyc;
            repeat (1100) tick();
            trig = (f || e) && !im;
            if (trig) begin
                check(first_we == mark + 1, "R1 first write timing", first_we, mark + 1);
                check(last_we == mark + 1000, "R4 last write timing", last_we, mark + 1000);
                check(done_at == last_we + 1, "R4 done after last write", done_at, last_we + 1);
                check(done_cnt == 1, "R12 one done pulse", done_cnt, 1);
                check(wr_cnt == 1000, "R4 hardware write count", wr_cnt, 1000);
                verify_mem(1, p, 8'hAA, "R2 R3 hardware rows");
            end else begin
                check(wr_cnt == 0, im ? "R9 ids header ignored" : "R1 no trigger", wr_cnt, 0);
                check(done_cnt == 0, "R9 no done", done_cnt, 0);
                verify_mem(0, p, 8'hAA, "R9 memory untouched");
            end
        end
        ids_mode = 1'b0;

        // R5 R7: software clear waits for the line
        fill(8'hAA);
        clr_stats();
        pulse_sw();
        tick();
        check(sw_clear_busy == 1'b1, "R5 busy after request", sw_clear_busy, 1);
        repeat (50) tick();
        check(wr_cnt == 0, "R5 no write before line", wr_cnt, 0);
        pulse_line();
        mark = ncyc;
        repeat (1250) tick();
        check(first_we == mark + 1, "R5 full clear start", first_we, mark + 1);
        check(wr_cnt == 1160, "R5 full write count", wr_cnt, 1160);
        check(fall_at == done_at && done_at == last_we + 1, "R7 busy fall with done", fall_at, done_at);
        verify_mem(2, 1'b0, 8'hAA, "R5 full memory");

        // R6: hardware and software in the same line
        fill(8'hAA);
        clr_stats();
        pulse_sw();
        pulse_hdr(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (1100) tick();
        check(wr_cnt == 1000, "R6 hardware wins the line", wr_cnt, 1000);
        check(sw_clear_busy == 1'b1, "R6 software still pending", sw_clear_busy, 1);
        verify_mem(1, 1'b1, 8'hAA, "R6 only hardware rows");
        pulse_line();
        repeat (1250) tick();
        check(wr_cnt == 2160, "R6 deferred full clear", wr_cnt, 2160);
        check(sw_clear_busy == 1'b0, "R7 busy cleared", sw_clear_busy, 0);
        verify_mem(2, 1'b0, 8'hAA, "R6 full after defer");

        // R6 R12: hardware interrupts a running software clear
        fill(8'hAA);
        clr_stats();
        pulse_sw();
        pulse_line();
        repeat (100) tick();
        pulse_hdr(1'b0, 1'b1, 1'b0, 1'b0);
        repeat (1100) tick();
        check(done_cnt == 1, "R12 no done for interrupted clear", done_cnt, 1);
        check(sw_clear_busy == 1'b1, "R6 interrupted stays pending", sw_clear_busy, 1);
        pulse_line();
        repeat (1250) tick();
        check(done_cnt == 2 && sw_clear_busy == 1'b0, "R6 rerun completes", done_cnt, 2);
        verify_mem(2, 1'b0, 8'hAA, "R6 rerun memory");

        // R10: counter reset in ids mode
        ids_mode = 1'b1;
        clr_stats();
        pulse_sw();
        pulse_line();
        repeat (1250) tick();
        check(rst_cnt == 1, "R10 one counter reset", rst_cnt, 1);
        check(rst_at == done_at, "R10 reset with done", rst_at, done_at);
        ids_mode = 1'b0;

        // R11: acquisition priority
        acq_we = 1'b1; acq_area = 1'b0; acq_row = 5'd0; acq_col = 6'd7; acq_data = 8'h77;
        tick();
        acq_we = 1'b0;
        tick();
        check(shadow[0][0][7] == 8'h77, "R11 idle pass-through", int'(shadow[0][0][7]), 'h77);
        pulse_hdr(1'b1, 1'b0, 1'b1, 1'b0);
        repeat (10) tick();
        acq_we = 1'b1; acq_data = 8'h66;
        tick();
        acq_we = 1'b0;
        repeat (1100) tick();
        check(shadow[0][0][7] == 8'h77, "R11 write dropped during clear", int'(shadow[0][0][7]), 'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule